// File: doc/BRIEF.md
# Dual-Stage Watchdog Timer

This block is a watchdog timer that counts pulses of a slow tick, nominally 32 kHz. Software keeps it quiet by writing a restart word before the programmed interval runs out. If the interval expires in single-stage operation, the block emits a system reset pulse. In dual-stage operation the first expiry raises an interrupt level and starts a second interval of the same length. If no restart arrives before that second interval ends, the reset pulse follows.

Software reaches the block through a word-wide register bus with byte offsets. Every write that changes state must carry a fixed key in a defined field; a write with the wrong key leaves the block unchanged. A separate register lets software request an immediate reset. The interval is set in units of `UNIT_TICKS` ticks. With the default of 512, one second is 64 units, so timeouts of 2 to 31 seconds fit the 11-bit field.

Top module: `wdt_dual_stage`

## Requirements
- R1: After reset the control word reads 0 at offset 0x00, the interval reads `LEN_RST << 5` at offset 0x04, and both `irq` and `sys_rst` are low.
- R2: A write to offset 0x00 updates the controls only when bits [31:24] equal 0x22. The control bits are run = bit 0, reset-out enable = bit 2, interrupt enable = bit 3 and two-stage = bit 6. A read returns them in the same positions, with all other bits 0. A write with any other key is ignored.
- R3: A write to offset 0x04 stores bits [5+LEN_W-1:5] as the interval only when bits [4:0] equal 0x08. A read returns the interval at the same position, with bits [4:0] reading 0. A write with another key is ignored.
- R4: With run and reset-out enable set and two-stage clear, `sys_rst` rises in the cycle after the tick that completes interval × `UNIT_TICKS` ticks since the last reload. The count then reloads. An interval of 0 acts as 1.
- R5: With two-stage set, the first expiry raises `irq` (when interrupt enable is set) and reloads the count. The next expiry gives the `sys_rst` pulse and drops `irq`.
- R6: A write to offset 0x08 with bits [15:0] = 0x1971 reloads the count, clears the pending interrupt and returns to the first stage. Any other value is ignored.
- R7: A newly written interval takes effect at the next reload, not in the count already running.
- R8: With reset-out enable clear, an expiry in the final stage gives no `sys_rst`. The count still reloads.
- R9: A write to offset 0x14 with bits [15:0] = 0x1209 drives `sys_rst` high in the next cycle, whatever the controls hold. Other values are ignored.
- R10: `sys_rst` is never high in two consecutive cycles.
- R11: While run is clear, the count is held reloaded, and no interrupt or timer reset occurs. Setting run again starts a full interval.
- R12: A valid restart write in the same cycle as an expiring tick wins: neither stage advances, and a full interval starts from that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle enable per slow-clock tick |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | First-stage interrupt level |
| sys_rst | output | 1 | One-cycle system reset pulse |

## Verification
The dangerous overlap is a restart write arriving on the very tick that would expire the count. The bench drives the restart key and a tick high in the same cycle, right after a partial interval. It expects `irq` to stay low, and then expects the first-stage interrupt exactly one full interval later. The overlap of two consecutive software-reset writes is also provoked. The bench expects the pulse in the first cycle only.

// File: rtl/wdt_dual_stage.sv
module wdt_dual_stage #(
  parameter int LEN_W      = 11,
  parameter int UNIT_TICKS = 512,
  parameter int LEN_RST    = (1 << LEN_W) - 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        sys_rst
);

  localparam int PW = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1;
  localparam logic [PW-1:0] PLAST = PW'(UNIT_TICKS - 1);

  logic             m_en, m_ext, m_irq, m_dual;
  logic [LEN_W-1:0] len_q, ucnt;
  logic [PW-1:0]    presc;
  logic             stage, irq_q;

  logic mode_ok, len_ok, kick, swr, unit_wrap, expire, first_exp, final_exp;
  logic unused_bits;

  assign mode_ok   = bus_wr && bus_addr == 8'h00 && bus_wdata[31:24] == 8'h22;
  assign len_ok    = bus_wr && bus_addr == 8'h04 && bus_wdata[4:0] == 5'h08;
  assign kick      = bus_wr && bus_addr == 8'h08 && bus_wdata[15:0] == 16'h1971;
  assign swr       = bus_wr && bus_addr == 8'h14 && bus_wdata[15:0] == 16'h1209;
  assign unit_wrap = m_en && tick && presc == PLAST;
  assign expire    = unit_wrap && ucnt <= LEN_W'(1) && !kick;
  assign first_exp = expire && m_dual && !stage;
  assign final_exp = expire && !(m_dual && !stage);
  assign unused_bits = ^bus_wdata[23:16];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_en, m_ext, m_irq, m_dual} <= '0;
      len_q   <= LEN_W'(LEN_RST);
      ucnt    <= LEN_W'(LEN_RST);
      presc   <= '0;
      stage   <= 1'b0;
      irq_q   <= 1'b0;
      sys_rst <= 1'b0;
    end else begin
      if (mode_ok) begin
        m_en   <= bus_wdata[0];
        m_ext  <= bus_wdata[2];
        m_irq  <= bus_wdata[3];
        m_dual <= bus_wdata[6];
      end
      if (len_ok) len_q <= bus_wdata[5 +: LEN_W];

      if (!m_en || kick || expire) begin
        presc <= '0;
        ucnt  <= len_q;
      end else if (tick) begin
        if (presc == PLAST) begin
          presc <= '0;
          ucnt  <= ucnt - 1'b1;
        end else begin
          presc <= presc + 1'b1;
        end
      end

      if (!m_en || kick || final_exp) begin
        stage <= 1'b0;
        irq_q <= 1'b0;
      end else if (first_exp) begin
        stage <= 1'b1;
        irq_q <= 1'b1;
      end

      sys_rst <= !sys_rst && ((final_exp && m_ext) || swr);
    end
  end

  assign irq = irq_q && m_irq;

  always_comb begin
    case (bus_addr)
      8'h00:   bus_rdata = {25'd0, m_dual, 2'b00, m_irq, m_ext, 1'b0, m_en};
      8'h04:   bus_rdata = 32'(len_q) << 5;
      default: bus_rdata = '0;
    endcase
  end

  a_r2_bad_mode_key: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h00 && bus_wdata[31:24] != 8'h22)
      |=> $stable({m_en, m_ext, m_irq, m_dual}));

  a_r3_bad_len_key: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h04 && bus_wdata[4:0] != 5'h08) |=> $stable(len_q));

  a_r6_kick_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h08 && bus_wdata[15:0] == 16'h1971) |=> !irq);

  a_r9_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h14 && bus_wdata[15:0] == 16'h1209 && !sys_rst) |=> sys_rst);

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> !sys_rst);

  a_r11_halted_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!m_en && !(bus_wr && bus_addr == 8'h14 && bus_wdata[15:0] == 16'h1209))
      |=> (!sys_rst && !irq));

endmodule

// File: tb/test_wdt_dual_stage.sv
module test_wdt_dual_stage;
  localparam int LEN_W = 11;
  localparam int UNIT  = 4;
  localparam int LRST  = (1 << LEN_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, sys_rst;
  int checks = 0, fails = 0, rst_seen = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wdt_dual_stage #(.LEN_W(LEN_W), .UNIT_TICKS(UNIT)) i_wdt_dual_stage (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sys_rst(sys_rst));

  always @(negedge clk) if (sys_rst) rst_seen++;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic run(input int n);
    @(negedge clk);
    tick = 1'b1;
    for (int i = 0; i < n; i++) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h00, d); chk(d == 0, "R1 mode", d, 0);
    rd(8'h04, d); chk(d == 32'(LRST) << 5, "R1 length", d, 32'(LRST) << 5);
    chk(!irq && !sys_rst, "R1 outputs", {irq, sys_rst}, 0);
  endtask

  task automatic t_mode_key();
    logic [31:0] d;
    wr(8'h00, 32'h1100_004D); rd(8'h00, d); chk(d == 0, "R2 bad key", d, 0);
    wr(8'h00, 32'h2200_00FF); rd(8'h00, d); chk(d == 32'h4D, "R2 good key", d, 32'h4D);
    wr(8'h00, 32'h2200_0000);
  endtask

  task automatic t_len_key();
    logic [31:0] d;
    wr(8'h04, (3 << 5) | 9); rd(8'h04, d); chk(d == 32'(LRST) << 5, "R3 bad key", d, 32'(LRST) << 5);
    wr(8'h04, (3 << 5) | 8); rd(8'h04, d); chk(d == 3 << 5, "R3 good key", d, 3 << 5);
  endtask

  task automatic t_single();
    int s;
    wr(8'h00, 32'h2200_0005); wr(8'h08, 32'h1971);
    s = rst_seen;
    run(11); chk(rst_seen == s && !sys_rst, "R4 early", rst_seen - s, 0);
    run(1);  chk(sys_rst, "R4 expiry", sys_rst, 1);
    @(negedge clk); chk(!sys_rst, "R10 pulse width", sys_rst, 0);
  endtask

  task automatic t_dual();
    wr(8'h00, 32'h2200_004D); wr(8'h08, 32'h1971);
    run(11); chk(!irq, "R5 before first", irq, 0);
    run(1);  chk(irq && !sys_rst, "R5 first stage", {irq, sys_rst}, 2'b10);
    run(11); chk(irq && !sys_rst, "R5 second running", {irq, sys_rst}, 2'b10);
    run(1);  chk(sys_rst && !irq, "R5 second stage", {irq, sys_rst}, 2'b01);
  endtask

  task automatic t_kick();
    int s;
    wr(8'h08, 32'h1971);
    run(12); chk(irq, "R6 setup irq", irq, 1);
    wr(8'h08, 32'h1970); chk(irq, "R6 wrong key", irq, 1);
    wr(8'h08, 32'h1971); chk(!irq, "R6 restart clears", irq, 0);
    s = rst_seen;
    run(12); chk(irq && rst_seen == s, "R6 back to first stage", {irq, 8'(rst_seen - s)}, 9'h100);
    wr(8'h08, 32'h1971);
  endtask

  task automatic t_len_defer();
    int s;
    wr(8'h00, 32'h2200_0005); wr(8'h08, 32'h1971);
    wr(8'h04, (1 << 5) | 8);
    s = rst_seen;
    run(4);  chk(rst_seen == s, "R7 old length kept", rst_seen - s, 0);
    run(8);  chk(sys_rst, "R7 old length expiry", sys_rst, 1);
    run(4);  chk(sys_rst, "R7 new length next", sys_rst, 1);
  endtask

  task automatic t_noext();
    int s;
    wr(8'h00, 32'h2200_0001); wr(8'h08, 32'h1971);
    s = rst_seen;
    run(8); @(negedge clk);
    chk(rst_seen == s, "R8 no reset out", rst_seen - s, 0);
  endtask

  task automatic t_swrst();
    wr(8'h00, 32'h2200_0000);
    wr(8'h14, 32'h1208); chk(!sys_rst, "R9 bad value", sys_rst, 0);
    wr(8'h14, 32'h1209); chk(sys_rst, "R9 soft reset", sys_rst, 1);
    @(negedge clk); chk(!sys_rst, "R9 pulse ends", sys_rst, 0);
    bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h1209;
    @(negedge clk); chk(sys_rst, "R10 first of pair", sys_rst, 1);
    @(negedge clk); chk(!sys_rst, "R10 second of pair", sys_rst, 0);
    bus_wr = 1'b0;
  endtask

  task automatic t_disable();
    int s;
    wr(8'h00, 32'h2200_0005); wr(8'h08, 32'h1971);
    run(3);
    wr(8'h00, 32'h2200_0004);
    s = rst_seen;
    run(10); chk(rst_seen == s, "R11 halted", rst_seen - s, 0);
    wr(8'h00, 32'h2200_0005);
    run(3); chk(rst_seen == s, "R11 full interval", rst_seen - s, 0);
    run(1); chk(sys_rst, "R11 expiry after rerun", sys_rst, 1);
  endtask

  task automatic t_race();
    wr(8'h00, 32'h2200_004D); wr(8'h08, 32'h1971);
    run(3);
    @(negedge clk);
    tick = 1'b1; bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 32'h1971;
    @(negedge clk);
    tick = 1'b0; bus_wr = 1'b0;
    chk(!irq && !sys_rst, "R12 restart wins", {irq, sys_rst}, 0);
    run(3); chk(!irq, "R12 restarted count", irq, 0);
    run(1); chk(irq, "R12 full interval", irq, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mode_key();
    t_len_key();
    t_single();
    t_dual();
    t_kick();
    t_len_defer();
    t_noext();
    t_swrst();
    t_disable();
    t_race();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule